// File: doc/BRIEF.md
# Key-Sequenced Watchdog Countdown

This block is a watchdog counter that is controlled through one 32-bit configuration word. The word holds a preload value and two 2-bit key fields. Software never sets enable or service directly. Each action has to be unlocked by writing two key codes in order into its own field. A completed key in the service field reloads the countdown from the preload. A completed key in the enable field flips the running state, so the same sequence turns the watchdog on and also turns it off.

While the block is running, the counter moves down by one on every clock. The preload is scaled by a fixed power of two, so a large bus-cycle window fits in a narrow field. When the count reaches zero, the block emits a single-cycle expiry pulse. The count then rests at zero until it is serviced. Whatever consumes the pulse (interrupt, reset) sits outside the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the preload is 0, the count is 0, the block is disabled, the expiry pulse is low and the read word is all zeros.
- R2: The preload (bits [PW-1:0]) is written only by a write in which both key fields are 2'b00. A write with a nonzero code in either key field leaves the preload unchanged.
- R3: The read word carries the preload in [PW-1:0] and the running state in bit 31. All other bits read as zero, including the key fields [27:24].
- R4: The service field is bits [27:26]. Writing 2'b01 and then 2'b10 there reloads the count to preload·2^SHIFT. Writes that carry 2'b00 in that field may come between the two steps without breaking the sequence.
- R5: A key detector that is waiting for its first step stays idle on any code other than 2'b01. A detector waiting for its second step drops back to idle on 2'b11 or on a repeated 2'b01. After that, a fresh 2'b01 starts a new sequence.
- R6: The enable field is bits [25:24]. The same 01-then-10 sequence there toggles the running state, which is shown on `enabled`.
- R7: The count decrements once per clock only while the block is enabled. Disabling freezes the count, and re-enabling resumes from the frozen value unless a service happened in between.
- R8: When the count steps from 1 to 0 while enabled, `timeoutPulse` is high for exactly one cycle. It is visible preload·2^SHIFT clocks after the edge that completed the service. The count then holds at zero with no further pulses.
- R9: The count is PW+SHIFT bits wide (at most 32), so the largest preload expires after (2^PW−1)·2^SHIFT clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write word: key fields and preload |
| rdData | output | 32 | Read word: running state and preload |
| timeoutPulse | output | 1 | One-cycle expiry pulse |
| enabled | output | 1 | Running state |

## Verification
The bench builds the block with a 12-bit preload and a 4-bit scale shift. Each preload unit is then 16 clocks, so the exact expiry cycle of ordinary preloads can be predicted and compared within a short run. The all-ones preload expires after 65520 clocks. With these values the full-width boundary of the count can be reached, which is out of reach with the default 24-bit preload and 8-bit shift.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int WORD_W     = 32;
  localparam int EN_LSB     = 24;
  localparam int SVC_LSB    = 26;
  localparam int STATUS_BIT = 31;

  localparam logic [1:0] KEY_IDLE   = 2'b00;
  localparam logic [1:0] KEY_FIRST  = 2'b01;
  localparam logic [1:0] KEY_SECOND = 2'b10;

  typedef struct packed {
    logic reload;
    logic toggleEn;
    logic setPreload;
  } wdStrobe_t;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] code,
  output logic       fire
);
  logic armed;

  assign fire = wrEn && armed && (code == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrEn && code != KEY_IDLE) begin
      if (!armed) armed <= (code == KEY_FIRST);
      else        armed <= 1'b0;
    end
  end

  // R5: a completed key always leaves the detector idle
  assert_fire_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !armed);
  // R5: a repeated first step while armed returns to idle
  assert_repeat_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && armed && code == KEY_FIRST) |=> !armed);
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output wdStrobe_t         st
);
  localparam int NKEYS = 2;
  logic [NKEYS-1:0] keyFire;
  logic [NKEYS-1:0] keyZero;

  for (genvar g = 0; g < NKEYS; g++) begin : gKey
    localparam int LSB = EN_LSB + 2 * g;
    kwd_key_seq uKey (
      .clk  (clk),
      .rstN (rstN),
      .wrEn (wrEn),
      .code (wrData[LSB+1:LSB]),
      .fire (keyFire[g])
    );
    assign keyZero[g] = (wrData[LSB+1:LSB] == KEY_IDLE);
  end

  always_comb begin
    st            = '0;
    st.toggleEn   = keyFire[0];
    st.reload     = keyFire[1];
    st.setPreload = wrEn && (&keyZero);
  end

  // R2: a preload update never coincides with a key action
  assert_preload_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.setPreload |-> !(st.reload || st.toggleEn));
endmodule

// File: rtl/kwd_path.sv
module kwd_path
  import kwd_pkg::*;
#(
  parameter int PW    = 24,
  parameter int SHIFT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdStrobe_t     st,
  input  logic [PW-1:0] preloadIn,
  output logic [PW-1:0] preloadQ,
  output logic          enQ,
  output logic          pulseQ
);
  localparam int CW = PW + SHIFT;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preloadQ <= '0;
      enQ      <= 1'b0;
      cnt      <= '0;
      pulseQ   <= 1'b0;
    end else begin
      if (st.setPreload) preloadQ <= preloadIn;
      if (st.toggleEn)   enQ      <= !enQ;
      if (st.reload)
        cnt <= {preloadQ, {SHIFT{1'b0}}};
      else if (enQ && cnt != '0)
        cnt <= cnt - 1'b1;
      pulseQ <= enQ && !st.reload && (cnt == CW'(1));
    end
  end

  // R8: the expiry pulse lasts one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);
  // R7: a disabled counter without reload does not move
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !st.reload) |=> $stable(cnt));
  // R4: a reload lands the scaled preload
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.reload |=> (cnt == {$past(preloadQ), {SHIFT{1'b0}}}));
  // R2: preload moves only on a preload write
  assert_preload_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !st.setPreload |=> $stable(preloadQ));
  // R8: a pulse means the count is resting at zero
  assert_zero_after_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> (cnt == '0 || $past(st.reload)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int PW    = 24,
  parameter int SHIFT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        timeoutPulse,
  output logic        enabled
);
  wdStrobe_t     st;
  logic [PW-1:0] preloadQ;

  initial begin
    assert (PW <= EN_LSB && PW + SHIFT <= WORD_W)
      else $error("R9: preload and scale exceed the field layout");
  end

  kwd_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .st     (st)
  );

  kwd_path #(.PW(PW), .SHIFT(SHIFT)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .preloadIn (wrData[PW-1:0]),
    .preloadQ  (preloadQ),
    .enQ       (enabled),
    .pulseQ    (timeoutPulse)
  );

  always_comb begin
    rdData             = '0;
    rdData[PW-1:0]     = preloadQ;
    rdData[STATUS_BIT] = enabled;
  end
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int PW = 12;
  localparam int SHIFT = 4;
  localparam int UNIT = 1 << SHIFT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timeoutPulse;
  logic        enabled;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int lastEdge = 0;
  bit done = 0;
  int    expQ[$];
  string tagQ[$];

  keyed_watchdog #(.PW(PW), .SHIFT(SHIFT)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .timeoutPulse(timeoutPulse), .enabled(enabled)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input logic [1:0] svc, input logic [1:0] en,
                                     input logic [11:0] pre);
    return {4'b0, svc, en, 12'b0, pre};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    lastEdge = cyc;
  endtask

  task automatic expectAt(input int c, input string req);
    expQ.push_back(c);
    tagQ.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && timeoutPulse) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R8: unexpected pulse at cycle %0d, expected none", cyc);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s: pulse at cycle %0d expected %0d", t, cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k, k2, k3;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 read", rdData, 32'h0);
    chk("R1 enabled", {31'b0, enabled}, 32'h0);
    chk("R1 pulse", {31'b0, timeoutPulse}, 32'h0);

    // R2 preload-only write, R3 read layout
    wr(mk(0, 0, 12'h005));
    chk("R2 preload", rdData, 32'h0000_0005);
    // R6 enable key; count is zero so no pulse may follow
    wr(mk(0, 1, 0)); wr(mk(0, 2, 0));
    chk("R6 enabled", {31'b0, enabled}, 32'h1);
    chk("R3 status bit", rdData, 32'h8000_0005);
    // R2 key write keeps preload; R3 key fields read zero
    wr(mk(1, 0, 12'hABC));
    chk("R2 key keeps preload", rdData, 32'h8000_0005);
    // R4 second step completes service
    wr(mk(2, 0, 0));
    k = lastEdge;
    expectAt(k + 5 * UNIT, "R4");
    idle(5 * UNIT + 40);
    chk("R8 still enabled", {31'b0, enabled}, 32'h1);

    // R5 broken sequences: no reload, so no pulse
    wr(mk(1, 0, 0)); wr(mk(3, 0, 0)); wr(mk(2, 0, 0));
    idle(5 * UNIT + 20);
    wr(mk(1, 0, 0)); wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    idle(5 * UNIT + 20);
    wr(mk(2, 0, 0));
    idle(5 * UNIT + 20);
    // R5 restart after a repeated first step
    wr(mk(1, 0, 0)); wr(mk(1, 0, 0)); wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    k = lastEdge;
    expectAt(k + 5 * UNIT, "R5");
    idle(5 * UNIT + 20);

    // R4 preload write between key steps
    wr(mk(1, 0, 0)); wr(mk(0, 0, 12'h007)); wr(mk(2, 0, 0));
    k = lastEdge;
    expectAt(k + 7 * UNIT, "R4");
    chk("R4 new preload", rdData, 32'h8000_0007);
    idle(7 * UNIT + 30);

    // R7 freeze and resume
    wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    k = lastEdge;
    idle(30);
    wr(mk(0, 1, 0)); wr(mk(0, 2, 0));
    k2 = lastEdge;
    chk("R6 disabled", {31'b0, enabled}, 32'h0);
    idle(150);
    wr(mk(0, 1, 0)); wr(mk(0, 2, 0));
    k3 = lastEdge;
    expectAt(k3 + 7 * UNIT - (k2 - k), "R7");
    idle(7 * UNIT + 30);

    // R7 service while disabled restarts the full window
    wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    idle(20);
    wr(mk(0, 1, 0)); wr(mk(0, 2, 0));
    wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    idle(50);
    wr(mk(0, 1, 0)); wr(mk(0, 2, 0));
    k3 = lastEdge;
    expectAt(k3 + 7 * UNIT, "R7");
    idle(7 * UNIT + 30);

    // R9 largest preload
    wr(mk(0, 0, 12'hFFF));
    chk("R9 preload", rdData, 32'h8000_0FFF);
    wr(mk(1, 0, 0)); wr(mk(2, 0, 0));
    k = lastEdge;
    expectAt(k + 4095 * UNIT, "R9");
    idle(4095 * UNIT + 40);

    chk("R8 all pulses seen", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule